// File: doc/BRIEF.md
# Interrupt-Capable Register-Mapped Pin Bank

This block is a general-purpose pin controller for up to 32 pins. Software reaches it through a plain word-addressed register port: an address, a write strobe, write data, and read data. Each pin can drive an output level or act as an input. Every pin also has its own interrupt detector, which can be set to react to a high level, a low level, a rising edge, a falling edge, or both edges.

Detected events are latched into a raw status register and cleared by writing ones to an acknowledge register. A pending view shows the raw status masked by the per-pin enables. A single interrupt line reports whether any pending bit is set, so the block can hang off one interrupt input of a larger system.

Input pins are resynchronised before they are detected or read back. A read-only version register tells software whether the both-edges detection mode exists.

Top module: `pinbank_irq`

## Requirements
- R1: After a synchronous reset these registers are all zero: output levels, direction, enable, edge-select, polarity and both-edges. Every pin is then an output driving 0 (pin_oe all ones, pin_out all zeros), the pending view reads 0, and irq_out is low.
- R2: Registers sit at these word addresses: 0 level, 1 direction, 2 interrupt enable, 3 raw status, 4 pending, 5 acknowledge, 6 edge-select, 7 polarity, 8 version, 9 both-edges. A direction bit of 1 makes its pin an input (pin_oe low). A direction bit of 0 makes it an output that drives the matching bit of the level register on pin_out.
- R3: Reading word 0 returns, for each input pin, its level after a two-flop synchronizer, and for each output pin the level it drives. Read data is registered and appears after the clock edge that samples the address.
- R4: When edge-select is 0 the pin is level-triggered. Polarity 1 latches an event while the synchronized input is high, and polarity 0 latches one while it is low. The raw bit stays set after an acknowledge for as long as the active level remains.
- R5: When edge-select is 1 and both-edges is 0, polarity 1 latches an event only on a rising edge and polarity 0 only on a falling edge. The opposite edge leaves the raw bit unchanged.
- R6: When edge-select and both-edges are both 1, every transition latches an event whatever the polarity bit holds.
- R7: Writing to the acknowledge word clears each raw bit written as 1 and leaves bits written as 0 alone. If an event is detected in the same cycle as the acknowledge of that bit, the bit stays set.
- R8: The pending word equals raw status AND enable. irq_out is a register that goes high one cycle after any pending bit is set and low one cycle after none is.
- R9: The version word reads the VERSION parameter, which defaults to 3 and means both-edges is present. Writes to the raw status, pending and version words change nothing.
- R10: Register bits at or above the PINS parameter read as 0, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PINS | Asynchronous pin levels from the pads |
| pin_out | output | PINS | Levels to drive on output pins |
| pin_oe | output | PINS | Drive enable per pin, high for outputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench lines up a rising edge with an acknowledge of the same bit in the same cycle. A design that lets the clear win would lose that event and read the bit back as 0. It acknowledges a level-triggered pin while the level is still active, which catches a design that treats levels as one-shot edges and leaves the raw bit clear. Each single-edge mode gets the opposite edge, which a design that wires polarity wrongly or ignores it would latch. In both-edges mode the bench sends a falling edge with polarity set for rising, which would be missed by a design that still applies polarity. It also writes to the read-only words and sends a write-zero acknowledge. A design that decodes writes too loosely would corrupt the latched status in either case.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned MAX_PINS = 32;

  typedef enum logic [SEL_W-1:0] {
    SEL_LEVEL = 4'd0,
    SEL_DIR   = 4'd1,
    SEL_IEN   = 4'd2,
    SEL_RAW   = 4'd3,
    SEL_PEND  = 4'd4,
    SEL_ACK   = 4'd5,
    SEL_EDGE  = 4'd6,
    SEL_POL   = 4'd7,
    SEL_VER   = 4'd8,
    SEL_ANY   = 4'd9
  } sel_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] lvl,
  input  logic [PINS-1:0] edge_sel,
  input  logic [PINS-1:0] pol_sel,
  input  logic [PINS-1:0] any_sel,
  output logic [PINS-1:0] evt
);
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      always_comb begin
        if (!edge_sel[i])
          evt[i] = pol_sel[i] ? lvl[i] : ~lvl[i];
        else if (any_sel[i])
          evt[i] = lvl[i] ^ prev_q[i];
        else if (pol_sel[i])
          evt[i] = lvl[i] & ~prev_q[i];
        else
          evt[i] = ~lvl[i] & prev_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/pinbank_latch.sv
module pinbank_latch #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] evt,
  input  logic            ack_we,
  input  logic [PINS-1:0] ack_bits,
  input  logic [PINS-1:0] ien,
  output logic [PINS-1:0] raw_q,
  output logic [PINS-1:0] pend,
  output logic            irq_q
);
  logic [PINS-1:0] clr_mask;

  assign clr_mask = ack_we ? ack_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= (raw_q & ~clr_mask) | evt;
  end

  assign pend = raw_q & ien;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned VERSION     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_oe,
  output logic             irq_out
);
  localparam bit HAS_ANY = (VERSION >= 3);

  logic [PINS-1:0] wbits;
  logic [PINS-1:0] out_q, dir_q, ien_q, edge_q, pol_q, oe_q, any_q;
  logic [PINS-1:0] lvl_sync, lvl_view, evt, raw_q, pend;
  logic            irq_q, ack_we;
  logic [BUS_W-1:0] rd_word, rdata_q;

  assign wbits  = bus_wdata[PINS-1:0];
  assign ack_we = bus_we && (bus_addr == SEL_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      oe_q   <= '1;
      ien_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        SEL_LEVEL: out_q <= wbits;
        SEL_DIR: begin
          dir_q <= wbits;
          oe_q  <= ~wbits;
        end
        SEL_IEN:   ien_q  <= wbits;
        SEL_EDGE:  edge_q <= wbits;
        SEL_POL:   pol_q  <= wbits;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_ANY) begin : g_any
      logic [PINS-1:0] any_r;
      always_ff @(posedge clk) begin
        if (rst)                                  any_r <= '0;
        else if (bus_we && (bus_addr == SEL_ANY)) any_r <= wbits;
      end
      assign any_q = any_r;
    end else begin : g_no_any
      assign any_q = '0;
    end
  endgenerate

  pinbank_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .q_sync  (lvl_sync)
  );

  pinbank_detect #(.PINS(PINS)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl_sync),
    .edge_sel (edge_q),
    .pol_sel  (pol_q),
    .any_sel  (any_q),
    .evt      (evt)
  );

  pinbank_latch #(.PINS(PINS)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .ack_we   (ack_we),
    .ack_bits (wbits),
    .ien      (ien_q),
    .raw_q    (raw_q),
    .pend     (pend),
    .irq_q    (irq_q)
  );

  assign lvl_view = (dir_q & lvl_sync) | (~dir_q & out_q);

  always_comb begin
    case (bus_addr)
      SEL_LEVEL: rd_word = BUS_W'(lvl_view);
      SEL_DIR:   rd_word = BUS_W'(dir_q);
      SEL_IEN:   rd_word = BUS_W'(ien_q);
      SEL_RAW:   rd_word = BUS_W'(raw_q);
      SEL_PEND:  rd_word = BUS_W'(pend);
      SEL_EDGE:  rd_word = BUS_W'(edge_q);
      SEL_POL:   rd_word = BUS_W'(pol_q);
      SEL_VER:   rd_word = BUS_W'(VERSION);
      SEL_ANY:   rd_word = BUS_W'(any_q);
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = oe_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
  import pinbank_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] bus_addr,
  input logic             bus_we,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [PINS-1:0]  evt,
  input logic [PINS-1:0]  raw_q,
  input logic [PINS-1:0]  ien_q,
  input logic [PINS-1:0]  pin_out,
  input logic             irq_out
);
  // R8: combined line follows the previous cycle's masked status
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == |($past(raw_q) & $past(ien_q))));

  // R7: acknowledged bits clear unless an event arrives in the same cycle
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == SEL_ACK) |=>
      ((raw_q & $past(bus_wdata[PINS-1:0]) & ~$past(evt)) == '0));

  // R7: raw bits are sticky without an acknowledge
  p_raw_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == SEL_ACK) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  // R4: a detected event is always latched
  p_evt_latched_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(evt)) == $past(evt)));

  // R2: driven levels only change on a write to the level word
  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == SEL_LEVEL) |=> $stable(pin_out));
endmodule

bind pinbank_irq pinbank_irq_chk #(.PINS(PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .evt       (evt),
  .raw_q     (raw_q),
  .ien_q     (ien_q),
  .pin_out   (pin_out),
  .irq_out   (irq_out)
);

// File: tb/test_pinbank_irq.sv
module test_pinbank_irq;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned NP     = 12;
  localparam logic [31:0] MASK   = 32'h0000_0FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pinbank_irq #(.PINS(NP)) i_pinbank_irq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
    settle(5);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pin_oe", 32'(pin_oe), MASK);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 irq_out", 32'(irq_out), 0);
    rd(4'd1, d); chk("R1 dir", d, 0);
    rd(4'd2, d); chk("R1 ien", d, 0);
    rd(4'd6, d); chk("R1 edge", d, 0);
    rd(4'd7, d); chk("R1 pol", d, 0);
    rd(4'd9, d); chk("R1 both", d, 0);
    rd(4'd4, d); chk("R1 pending", d, 0);
  endtask

  task automatic t_dir_level();
    logic [31:0] d;
    wr(4'd1, 32'h0F0);
    wr(4'd0, 32'hA5A);
    settle(1);
    chk("R2 pin_out", 32'(pin_out), 32'hA5A);
    chk("R2 pin_oe", 32'(pin_oe), 32'hF0F);
    @(negedge clk); pin_in = 12'h0C0;
    settle(3);
    rd(4'd0, d); chk("R3 level view", d, 32'hACA);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d); chk("R10 dir upper bits", d, MASK);
    rd(4'd0, d); chk("R3 all inputs", d, 32'h0C0);
    @(negedge clk); pin_in = '0;
    wr(4'd6, 32'hFFF);
    wr(4'd7, 32'hFFF);
    settle(3);
    wr(4'd5, 32'hFFF);
    rd(4'd3, d); chk("R7 clear all", d, 0);
  endtask

  task automatic t_single_edge();
    logic [31:0] d;
    wr(4'd2, 32'h008);
    set_pin(3, 1'b1);
    chk("R8 irq on rise", 32'(irq_out), 1);
    rd(4'd3, d); chk("R5 rising latched", d, 32'h008);
    rd(4'd4, d); chk("R8 pending", d, 32'h008);
    wr(4'd5, 32'h008);
    settle(2);
    chk("R8 irq after ack", 32'(irq_out), 0);
    set_pin(3, 1'b0);
    rd(4'd3, d); chk("R5 fall ignored in rising mode", d, 0);
    wr(4'd7, 32'hFF7);
    set_pin(3, 1'b1);
    rd(4'd3, d); chk("R5 rise ignored in falling mode", d, 0);
    set_pin(3, 1'b0);
    rd(4'd3, d); chk("R5 falling latched", d, 32'h008);
    wr(4'd5, 32'h008);
    wr(4'd7, 32'hFFF);
    wr(4'd2, 32'h000);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(4'd9, 32'h020);
    set_pin(5, 1'b1);
    rd(4'd3, d); chk("R6 rise in both mode", d, 32'h020);
    wr(4'd5, 32'h020);
    set_pin(5, 1'b0);
    rd(4'd3, d); chk("R6 fall in both mode", d, 32'h020);
    wr(4'd5, 32'h020);
    rd(4'd3, d); chk("R6 cleared", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(4'd6, 32'hEFF);
    settle(2);
    wr(4'd5, 32'h100);
    rd(4'd3, d); chk("R4 high level idle", d, 0);
    set_pin(8, 1'b1);
    wr(4'd5, 32'h100);
    rd(4'd3, d); chk("R4 level persists after ack", d, 32'h100);
    set_pin(8, 1'b0);
    wr(4'd5, 32'h100);
    rd(4'd3, d); chk("R4 level gone", d, 0);
    wr(4'd7, 32'hEFF);
    settle(2);
    rd(4'd3, d); chk("R4 low level", d, 32'h100);
    wr(4'd6, 32'hFFF);
    wr(4'd7, 32'hFFF);
    wr(4'd5, 32'hFFF);
    rd(4'd3, d); chk("R4 restored", d, 0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    set_pin(3, 1'b1);
    set_pin(5, 1'b1);
    rd(4'd3, d); chk("R7 two events", d, 32'h028);
    wr(4'd5, 32'h008);
    rd(4'd3, d); chk("R7 partial ack", d, 32'h020);
    wr(4'd5, 32'h000);
    rd(4'd3, d); chk("R7 zero ack no effect", d, 32'h020);
    wr(4'd5, 32'hFFF);
    // edge and ack of the same bit meet at one clock edge
    @(negedge clk); pin_in[1] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); bus_addr = 4'd5; bus_wdata = 32'h002; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(4'd3, d); chk("R7 edge wins over ack", d, 32'h002);
    wr(4'd5, 32'h002);
    rd(4'd3, d); chk("R7 later ack clears", d, 0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    set_pin(3, 1'b0);
    wr(4'd5, 32'hFFF);
    wr(4'd3, 32'hFFF);
    wr(4'd4, 32'hFFF);
    wr(4'd8, 32'hFFF);
    rd(4'd8, d); chk("R9 version", d, 32'd3);
    rd(4'd3, d); chk("R9 raw not writable", d, 0);
    rd(4'd4, d); chk("R9 pending not writable", d, 0);
    set_pin(3, 1'b1);
    rd(4'd4, d); chk("R8 masked pending", d, 0);
    chk("R8 no irq while masked", 32'(irq_out), 0);
    wr(4'd2, 32'h008);
    settle(2);
    rd(4'd4, d); chk("R8 unmasked pending", d, 32'h008);
    chk("R8 irq when unmasked", 32'(irq_out), 1);
  endtask

  initial begin
    settle(3);
    @(negedge clk); rst = 1'b0;
    settle(1);
    t_reset();
    t_dir_level();
    t_single_edge();
    t_both();
    t_level();
    t_ack();
    t_readonly();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule